// File: doc/BRIEF.md
# Next-PC and Control-Flow Unit

This block owns the program counter of a single-cycle processor datapath with 16-bit byte addresses. Every rising clock edge it loads a new PC value. That value is one of three: the sequential successor (PC+4), an absolute destination taken straight from the 16-bit immediate field, or an absolute destination supplied by the register file's first read port. No PC-relative or segment arithmetic is applied to a destination.

The microcode ROM supplies several control lines: an unconditional jump line, a conditional branch line, an invert line for that branch, and a select for the second register read address. The instruction supplies a link bit and a destination-source select. The ALU, driven to subtract for branches, supplies its zero flag. A single branch line combined with the invert line gives both the branch-if-equal and branch-if-not-equal forms. The block also passes PC+4 on as link data and tells the register file which write-data source to use.

The register file that sits beside this block writes on the falling clock edge, in the middle of an instruction. Because of this, programs must begin with a no-op.

Top module: `pc_flow_unit`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0x0000 at the next rising edge.
- R2: `pc_plus_o` always equals `pc_o` + 4 modulo 2^16. At PC 0xFFFC it reads 0x0000.
- R3: When `jump_i` is 1, the next PC is the destination, whatever `branch_i`, `invert_i` and `zero_i` are.
- R4: When `jump_i` is 0, `branch_i` is 1, `invert_i` is 0 and `zero_i` is 1, the next PC is the destination (branch if equal).
- R5: When `jump_i` is 0, `branch_i` is 1, `invert_i` is 1 and `zero_i` is 0, the next PC is the destination (branch if not equal).
- R6: In every other combination of `jump_i`, `branch_i`, `invert_i` and `zero_i`, the next PC is `pc_plus_o`, wrapping from 0xFFFC to 0x0000.
- R7: The destination is `rd1_data_i` when `dest_reg_i` is 1, and `imm_i` when `dest_reg_i` is 0.
- R8: `wb_link_o` equals `link_i` combinationally. A value of 1 means the register file writes PC+4 instead of the ALU result.
- R9: `rd2_from_r0_o` equals `rd2_sel_i` combinationally. A value of 1 means the second read address comes from the r0 field instead of r2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| jump_i | input | 1 | Unconditional jump control line |
| branch_i | input | 1 | Conditional branch control line |
| invert_i | input | 1 | Inverts the sense of the zero flag for branches |
| zero_i | input | 1 | ALU zero flag |
| dest_reg_i | input | 1 | 1: destination from the register file; 0: from the immediate |
| imm_i | input | 16 | Immediate field, used as an absolute destination |
| rd1_data_i | input | 16 | Register-file read port 1 data |
| link_i | input | 1 | Link bit of the instruction |
| rd2_sel_i | input | 1 | Control line for the second read-address source |
| pc_o | output | 16 | Current program counter |
| pc_plus_o | output | 16 | PC + 4, the sequential successor and link value |
| wb_link_o | output | 1 | Write-data select: 1 = PC+4, 0 = ALU result |
| rd2_from_r0_o | output | 1 | Second read-address select: 1 = r0 field, 0 = r2 field |

## Verification
The PC rule is swept over all 32 combinations of jump, branch, invert, zero and destination source. The immediate and register destinations are given different values, so a wrong source pick, a lost jump priority or a wrong invert polarity each leads to a different PC. A jump to 0xFFFC followed by a plain step separates correct modulo-2^16 wrapping from overflow. Reset is asserted mid-run, away from zero, to show that the load is synchronous. The two pass-through selects are tried in all four combinations.

// File: rtl/pc_flow_pkg.sv
package pc_flow_pkg;
    localparam int PC_W = 16;

    typedef enum logic {
        WB_ALU  = 1'b0,
        WB_LINK = 1'b1
    } wb_src_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;
endpackage

// File: rtl/pc_dest_mux.sv
module pc_dest_mux #(
    parameter int W = 16
) (
    input  logic         use_reg,
    input  logic [W-1:0] reg_val,
    input  logic [W-1:0] imm_val,
    output logic [W-1:0] dest
);
    always_comb begin
        dest = use_reg ? reg_val : imm_val;
    end
endmodule

// File: rtl/pc_redirect.sv
module pc_redirect (
    input  logic jump,
    input  logic branch,
    input  logic invert,
    input  logic zero,
    output logic taken
);
    logic cond_met;

    always_comb begin
        // equal-compare when invert is low, not-equal when high
        cond_met = invert ? ~zero : zero;
        if (jump) begin
            taken = 1'b1;
        end else begin
            taken = branch & cond_met;
        end
    end
endmodule

// File: rtl/pc_flow_unit.sv
module pc_flow_unit #(
    parameter int ADDR_W = pc_flow_pkg::PC_W,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              jump_i,
    input  logic              branch_i,
    input  logic              invert_i,
    input  logic              zero_i,
    input  logic              dest_reg_i,
    input  logic [ADDR_W-1:0] imm_i,
    input  logic [ADDR_W-1:0] rd1_data_i,
    input  logic              link_i,
    input  logic              rd2_sel_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_plus_o,
    output logic              wb_link_o,
    output logic              rd2_from_r0_o
);
    localparam logic [ADDR_W-1:0] INCR = ADDR_W'(STEP);

    logic [ADDR_W-1:0] pc_d, pc_q;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] dest;
    logic              taken;
    pc_flow_pkg::wb_src_e wb_src;

    pc_dest_mux #(.W(ADDR_W)) u_dest (
        .use_reg (dest_reg_i),
        .reg_val (rd1_data_i),
        .imm_val (imm_i),
        .dest    (dest)
    );

    pc_redirect u_redir (
        .jump   (jump_i),
        .branch (branch_i),
        .invert (invert_i),
        .zero   (zero_i),
        .taken  (taken)
    );

    always_comb begin
        seq_pc = pc_q + INCR;
        wb_src = link_i ? pc_flow_pkg::WB_LINK : pc_flow_pkg::WB_ALU;
        if (rst) begin
            pc_d = '0;
        end else if (taken) begin
            pc_d = dest;
        end else begin
            pc_d = seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        pc_q <= pc_d;
    end

    assign pc_o          = pc_q;
    assign pc_plus_o     = seq_pc;
    assign wb_link_o     = (wb_src == pc_flow_pkg::WB_LINK);
    assign rd2_from_r0_o = rd2_sel_i;
endmodule

// File: rtl/pc_flow_unit_chk.sv
module pc_flow_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              jump_i,
    input logic              branch_i,
    input logic              invert_i,
    input logic              zero_i,
    input logic              dest_reg_i,
    input logic [ADDR_W-1:0] imm_i,
    input logic [ADDR_W-1:0] rd1_data_i,
    input logic              link_i,
    input logic              rd2_sel_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] pc_plus_o,
    input logic              wb_link_o,
    input logic              rd2_from_r0_o
);
    logic [ADDR_W-1:0] chk_dest;
    assign chk_dest = dest_reg_i ? rd1_data_i : imm_i;

    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (pc_o == '0));

    assert_seq_value_R2: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(pc_o) |-> (pc_plus_o == pc_o + ADDR_W'(STEP)));

    assert_jump_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (jump_i && !rst) |=> (pc_o == $past(chk_dest)));

    assert_beq_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && branch_i && !invert_i && zero_i) |=> (pc_o == $past(chk_dest)));

    assert_bne_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && branch_i && invert_i && !zero_i) |=> (pc_o == $past(chk_dest)));

    assert_fallthrough_R6: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && !(branch_i && (invert_i ^ zero_i))) |=> (pc_o == $past(pc_plus_o)));

    assert_link_sel_R8: assert property (@(posedge clk) disable iff (rst)
        wb_link_o == link_i);

    assert_rd2_sel_R9: assert property (@(posedge clk) disable iff (rst)
        rd2_from_r0_o == rd2_sel_i);
endmodule

bind pc_flow_unit pc_flow_unit_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) u_chk (
    .clk(clk), .rst(rst), .jump_i(jump_i), .branch_i(branch_i),
    .invert_i(invert_i), .zero_i(zero_i), .dest_reg_i(dest_reg_i),
    .imm_i(imm_i), .rd1_data_i(rd1_data_i), .link_i(link_i),
    .rd2_sel_i(rd2_sel_i), .pc_o(pc_o), .pc_plus_o(pc_plus_o),
    .wb_link_o(wb_link_o), .rd2_from_r0_o(rd2_from_r0_o)
);

// File: tb/pc_flow_unit_test.sv
module pc_flow_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, jump_i, branch_i, invert_i, zero_i, dest_reg_i;
    logic        link_i, rd2_sel_i;
    logic [15:0] imm_i, rd1_data_i;
    logic [15:0] pc_o, pc_plus_o;
    logic        wb_link_o, rd2_from_r0_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_flow_unit uut (
        .clk(clk), .rst(rst), .jump_i(jump_i), .branch_i(branch_i),
        .invert_i(invert_i), .zero_i(zero_i), .dest_reg_i(dest_reg_i),
        .imm_i(imm_i), .rd1_data_i(rd1_data_i), .link_i(link_i),
        .rd2_sel_i(rd2_sel_i), .pc_o(pc_o), .pc_plus_o(pc_plus_o),
        .wb_link_o(wb_link_o), .rd2_from_r0_o(rd2_from_r0_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctrl(input logic j, input logic b, input logic inv, input logic z,
                        input logic src, input logic [15:0] im, input logic [15:0] rv);
        jump_i = j; branch_i = b; invert_i = inv; zero_i = z;
        dest_reg_i = src; imm_i = im; rd1_data_i = rv;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; link_i = 1'b0; rd2_sel_i = 1'b0;
        ctrl(0, 0, 0, 0, 0, 16'h0, 16'h0);
        @(negedge clk); @(negedge clk);
        check("R1 reset pc", pc_o, 16'h0000);
        check("R2 pc+4 after reset", pc_plus_o, 16'h0004);
        rst = 1'b0;
        exp_pc = 16'h0000;

        // full sweep of the next-PC rule, both destination sources
        for (int p = 0; p < 32; p++) begin
            logic j, b, inv, z, src, take;
            logic [15:0] im, rv, dst;
            {j, b, inv, z, src} = p[4:0];
            im = 16'h1000 + 16'(p * 16'h0104);
            rv = 16'h8000 + 16'(p * 16'h0230);
            ctrl(j, b, inv, z, src, im, rv);
            dst  = src ? rv : im;
            take = j | (b & (inv ^ z));
            check("R2 pc+4 value", pc_plus_o, exp_pc + 16'd4);
            exp_pc = take ? dst : exp_pc + 16'd4;
            @(negedge clk);
            if (j)                  check("R3 jump priority", pc_o, exp_pc);
            else if (b && !inv && z) check("R4 branch equal", pc_o, exp_pc);
            else if (b && inv && !z) check("R5 branch not equal", pc_o, exp_pc);
            else                     check("R6 sequential", pc_o, exp_pc);
            if (take) check(src ? "R7 register destination" : "R7 immediate destination", pc_o, dst);
        end

        // synchronous reset from a nonzero PC
        ctrl(1, 0, 0, 0, 0, 16'h4444, 16'h0);
        @(negedge clk);
        check("R3 jump before reset", pc_o, 16'h4444);
        rst = 1'b1;
        #1 check("R1 no async clear", pc_o, 16'h4444);
        @(negedge clk);
        check("R1 mid-run reset", pc_o, 16'h0000);
        rst = 1'b0;

        // wrap at the top of the address space
        ctrl(1, 0, 0, 0, 1, 16'h0, 16'hFFFC);
        @(negedge clk);
        check("R7 register jump to top", pc_o, 16'hFFFC);
        check("R2 wrap of pc+4", pc_plus_o, 16'h0000);
        ctrl(0, 1, 0, 0, 0, 16'h1234, 16'h0);
        @(negedge clk);
        check("R6 wrap to zero", pc_o, 16'h0000);

        // pass-through selects
        for (int k = 0; k < 4; k++) begin
            link_i = k[0]; rd2_sel_i = k[1];
            #1;
            check("R8 write-data select", {15'b0, wb_link_o}, {15'b0, k[0]});
            check("R9 read-address select", {15'b0, rd2_from_r0_o}, {15'b0, k[1]});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule